// File: doc/BRIEF.md
# Edge-Polarity GPIO Interrupt Controller

This block is a sixteen-pin general-purpose I/O port attached to a small 16-bit register bus. Every pin is either an input or a driven output. Input pins are brought into the clock domain through a two-flop synchronizer. Each input pin can latch an interrupt on one edge direction, rising or falling, chosen per pin. One combined interrupt line reports whether any status bit is set.

Software sets a pin's direction, its output level, its edge polarity and its mask through the registers. Pending events are read from the status register and cleared by writing ones. Only 16-bit accesses have any effect. The bus has no back-pressure: an access presented with `bus_sel` high is taken on that rising edge. Read data appears on `bus_rdata` after that edge and holds until the next read.

Top module: `gpio16_edge_irq`

## Requirements
- R1: After reset, status reads 0 and `irq` is 0. Output data, direction, polarity, mask and pin enable all read 0xFFFF. `pin_out` and `pin_oe` are 0.
- R2: `pin_oe` is the inverse of the direction register (1 = input). `pin_out` equals output data AND NOT direction, one edge after an output-data write.
- R3: A write to the direction register updates `pin_out` and `pin_oe` on the same edge, using the stored output data under the new direction.
- R4: An unmasked input pin whose polarity bit is 1 latches its status bit, and `irq` rises, on the third rising edge after `pin_in` goes 0 to 1. The two edges before it leave `irq` low.
- R5: An unmasked input pin whose polarity bit is 0 latches on a 1-to-0 change and ignores a 0-to-1 change.
- R6: A pin whose mask bit is 1, or whose direction bit is 0, never sets its status bit.
- R7: Writing status clears each bit written as 1 and leaves the rest. `irq` stays high while any status bit remains and falls when the status word becomes zero.
- R8: A read of offset 0x00 returns the synchronized inputs AND the pin-enable register.
- R9: `bus_size` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. An access with `bus_size` other than 1 changes no register and reads 0.
- R10: Offsets are 0x00 input, 0x04 output data, 0x08 direction, 0x0C polarity, 0x10 mask, 0x14 status, 0x18 pin enable. A write to 0x00 or to any other offset changes nothing, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, taken on the rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | External pin levels, asynchronous |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A bad edge reference or a wrong polarity decode shows up as a status bit that is wrong, missing or extra. Because status feeds `irq` directly, this is visible on `irq` three edges after the pin change. A corrupted direction or output-data register shows on `pin_out` and `pin_oe` one edge after the write. Read-side faults, such as a wrong pin-enable AND or a bad offset decode, show on `bus_rdata` one edge after the read strobe.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DRIVE = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_POL   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FLAG  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PEN   = 8'h18;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio16_edge_latch.sv
module gpio16_edge_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mask,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev_q, hit, status_q, status_n;
  logic         irq_q;

  // per-pin edge selection
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic rise, fall;
    assign rise   = level[p] & ~prev_q[p];
    assign fall   = ~level[p] & prev_q[p];
    assign hit[p] = dir[p] & ~mask[p] & (pol[p] ? rise : fall);
  end

  // new events win over a clear in the same cycle
  always_comb status_n = (status_q & ~(clr_en ? clr_vec : '0)) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      prev_q   <= level;
      status_q <= status_n;
      irq_q    <= |status_n;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

  // R6
  gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) & ~($past(dir) & ~$past(mask))) == '0);
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((status_q & $past(clr_vec) & ~$past(hit)) == '0));
  // R7
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_q);
  // R7
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0) |-> irq_q);
endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
  import gpio16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      level,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      mask,
  output logic              clr_en,
  output logic [W-1:0]      clr_vec,
  output logic [W-1:0]      drive,
  output logic [W-1:0]      oe
);
  logic acc_ok, wr, rd;
  logic [W-1:0] dout_q, dir_q, pol_q, mask_q, pen_q;
  logic [W-1:0] dout_n, dir_n, pol_n, mask_n, pen_n;
  logic [W-1:0] drv_q, rmux, rdata_q;

  assign acc_ok = bus_sel && (bus_size == SZ_HALF);
  assign wr     = acc_ok && bus_we;
  assign rd     = acc_ok && !bus_we;

  always_comb begin
    dout_n = dout_q;
    dir_n  = dir_q;
    pol_n  = pol_q;
    mask_n = mask_q;
    pen_n  = pen_q;
    if (wr) begin
      case (bus_addr)
        OFF_DRIVE: dout_n = bus_wdata;
        OFF_DIR:   dir_n  = bus_wdata;
        OFF_POL:   pol_n  = bus_wdata;
        OFF_MASK:  mask_n = bus_wdata;
        OFF_PEN:   pen_n  = bus_wdata;
        default:   ;
      endcase
    end
  end

  assign clr_en  = wr && (bus_addr == OFF_FLAG);
  assign clr_vec = bus_wdata;

  always_comb begin
    case (bus_addr)
      OFF_LEVEL: rmux = level & pen_q;
      OFF_DRIVE: rmux = dout_q;
      OFF_DIR:   rmux = dir_q;
      OFF_POL:   rmux = pol_q;
      OFF_MASK:  rmux = mask_q;
      OFF_FLAG:  rmux = status;
      OFF_PEN:   rmux = pen_q;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '1;
      dir_q   <= '1;
      pol_q   <= '1;
      mask_q  <= '1;
      pen_q   <= '1;
      drv_q   <= '0;
      rdata_q <= '0;
    end else begin
      dout_q <= dout_n;
      dir_q  <= dir_n;
      pol_q  <= pol_n;
      mask_q <= mask_n;
      pen_q  <= pen_n;
      drv_q  <= dout_n & ~dir_n;
      if (bus_sel && !bus_we) rdata_q <= rd ? rmux : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign dir       = dir_q;
  assign pol       = pol_q;
  assign mask      = mask_q;
  assign drive     = drv_q;
  assign oe        = ~dir_q;

  // R2
  drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive & ~oe) == '0);
  // R9
  bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_size != SZ_HALF) |=>
      ($stable(dir_q) && $stable(dout_q) && $stable(mask_q) && $stable(pol_q) && $stable(pen_q)));
  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFF_DIR) |=> (oe == ~$past(bus_wdata)));
endmodule

// File: rtl/gpio16_edge_irq.sv
module gpio16_edge_irq
  import gpio16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  logic [W-1:0] level, status, dir, pol, mask, clr_vec;
  logic         clr_en;

  gpio16_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level)
  );

  gpio16_edge_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .level(level), .dir(dir), .pol(pol),
    .mask(mask), .clr_en(clr_en), .clr_vec(clr_vec),
    .status(status), .irq(irq)
  );

  gpio16_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .level(level), .status(status),
    .dir(dir), .pol(pol), .mask(mask), .clr_en(clr_en), .clr_vec(clr_vec),
    .drive(pin_out), .oe(pin_oe)
  );
endmodule

// File: tb/sim_gpio16_edge_irq.sv
module sim_gpio16_edge_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd1;
  logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio16_edge_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = 2'd1);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_size = 2'd1;
  endtask

  // driver: pushes the expected read data for the monitor
  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag, input logic [1:0] sz = 2'd1);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0; bus_size = 2'd1;
  endtask

  // monitor: pops and compares one item per read strobe
  always @(posedge clk) begin : mon
    logic armed;
    armed = bus_sel && !bus_we;
    #1;
    if (armed && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin_out", pin_out, 16'h0000);
    check("R1 pin_oe", pin_oe, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
    rd(8'h04, 16'hFFFF, "R1 dout");
    rd(8'h08, 16'hFFFF, "R1 dir");
    rd(8'h0C, 16'hFFFF, "R1 pol");
    rd(8'h10, 16'hFFFF, "R1 mask");
    rd(8'h14, 16'h0000, "R1 status");
    rd(8'h18, 16'hFFFF, "R1 pen");
    rd(8'h00, 16'h0000, "R1 input");

    // R2 / R3 drive behaviour
    wr(8'h04, 16'hA5C3);
    check("R2 all inputs", pin_out, 16'h0000);
    wr(8'h08, 16'hFF00);
    check("R3 oe after dir", pin_oe, 16'h00FF);
    check("R3 out after dir", pin_out, 16'h00C3);
    wr(8'h04, 16'h1234);
    check("R2 out after dout", pin_out, 16'h0034);

    // R4 rising capture with exact latency
    wr(8'h10, 16'h00FF);
    wr(8'h0C, 16'h0F00);
    @(negedge clk); pin_in = 16'h0100;
    repeat (2) @(negedge clk);
    check("R4 irq not early", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    check("R4 irq raised", {15'b0, irq}, 16'h0001);
    rd(8'h14, 16'h0100, "R4 status rise");

    // R5 falling polarity
    pins(16'h1100);
    rd(8'h14, 16'h0100, "R5 rise ignored");
    pins(16'h0100);
    rd(8'h14, 16'h1100, "R5 fall latched");

    // R6 masked and output pins
    wr(8'h10, 16'h02FF);
    pins(16'h0301);
    pins(16'h0100);
    rd(8'h14, 16'h1100, "R6 masked/output no latch");

    // R8 input read with pin enable
    wr(8'h18, 16'hF0FF);
    pins(16'h0F0F);
    rd(8'h00, 16'h000F, "R8 input and pen");
    rd(8'h14, 16'h1D00, "R4 new rises");

    // R7 write-one-to-clear
    wr(8'h14, 16'h1000);
    rd(8'h14, 16'h0D00, "R7 partial clear");
    check("R7 irq held", {15'b0, irq}, 16'h0001);
    wr(8'h14, 16'h0D00);
    @(negedge clk);
    check("R7 irq dropped", {15'b0, irq}, 16'h0000);
    rd(8'h14, 16'h0000, "R7 status zero");

    // R9 width, R10 offsets
    wr(8'h08, 16'h0000, 2'd2);
    rd(8'h08, 16'hFF00, "R9 word write ignored");
    wr(8'h04, 16'h0000, 2'd0);
    check("R9 byte write no drive change", pin_out, 16'h0034);
    rd(8'h08, 16'h0000, "R9 byte read zero", 2'd0);
    wr(8'h00, 16'hFFFF);
    rd(8'h00, 16'h000F, "R10 input write ignored");
    wr(8'h1C, 16'h0000);
    rd(8'h1C, 16'h0000, "R10 unknown reads zero");
    rd(8'h10, 16'h02FF, "R10 mask intact");

    // R3 back to all inputs
    wr(8'h08, 16'hFFFF);
    check("R3 out released", pin_out, 16'h0000);
    check("R3 oe released", pin_oe, 16'h0000);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule